// File: doc/BRIEF.md
# LED Driver Fault Supervisor

This block is the digital fault supervisor of a boost-converter LED backlight driver. It takes fault flags that have already been synchronised to its clock: output overvoltage, switch-node overvoltage (a lost rectifier diode), boost overcurrent, overtemperature with its temperature-recovered companion flag, a per-channel shorted-string flag, input undervoltage and soft-start timeout. A fault-mode select and the enable input decide how each fault is handled. With `mode_auto` low, most faults latch the device off. With `mode_auto` high, most faults recover by themselves. Two faults always latch, whatever the mode.

The block drives four things: a shutdown request for the power stage, a request to rerun soft start, a per-channel string-disable mask, and the pull-down enable of an active-low open-drain fault pin. A 3-bit cause code records the fault that first forced a latched shutdown.

Every fault input passes a two-clock stability filter before the state machine sees it. The machine has five states:
- `ST_OFF`: enable is low.
- `ST_RUN`: normal operation.
- `ST_LATCH`: latched shutdown.
- `ST_HOT`: auto-mode thermal wait.
- `ST_UV`: undervoltage hold.

Transitions:
- Undervoltage goes to `ST_UV` from any state, and this has the highest priority.
- Enable low goes to `ST_OFF` from any state.
- `ST_OFF` and `ST_UV` go to `ST_RUN` once they are released with enable high.
- `ST_RUN` goes to `ST_LATCH` on a latching event.
- `ST_RUN` goes to `ST_HOT` on overtemperature in auto mode.
- `ST_HOT` goes to `ST_RUN` when the temperature-recovered flag is set and overtemperature is clear.
- `ST_HOT` goes to `ST_LATCH` on a latching event.
- `ST_LATCH` stays put until enable falls or undervoltage appears.

Top module: `led_fault_supervisor`

## Requirements
- R1: While reset is applied or enable is low, `shutdown` is 1, and `restart_ss`, `fault_pd`, `str_disable` and `first_cause` are 0. Enable high with no fault gives `shutdown` 0.
- R2: A fault input acts only once it has held the same value on two consecutive clock edges. A level that lasts one cycle has no effect. A fault raised before edge k changes `shutdown` after edge k+2.
- R3: With `mode_auto` 0, output overvoltage, overcurrent, overtemperature and soft-start timeout each force a latched shutdown.
- R4: Switch-node overvoltage, and a shorted-string flag on an active channel, force a latched shutdown in both modes.
- R5: With `mode_auto` 1 and no latching fault, overcurrent or soft-start timeout holds `restart_ss` at 1 while present. `shutdown` stays 0.
- R6: With `mode_auto` 1, overtemperature shuts the device down. It stays down until the temperature-recovered flag is 1 and overtemperature is 0, and then it resumes without any enable toggle.
- R7: With `mode_auto` 1, output overvoltage sets the `str_disable` bit of every channel that is set in `active_mask` and clear in `in_reg`. Other channels keep running and `shutdown` stays 0. The bits hold until enable goes low or undervoltage occurs.
- R8: A latched shutdown persists after its fault disappears. Only enable low or undervoltage clears it.
- R9: Undervoltage forces `shutdown` while present and clears the latch and the cause code. After it is released with enable high, the device runs again.
- R10: A shorted-string flag on a channel whose `active_mask` bit is 0 has no effect on any output.
- R11: `fault_pd` is 1 in latched shutdown, thermal wait and undervoltage, and while `restart_ss` or auto-mode overvoltage trimming is active. Otherwise it is 0.
- R12: `first_cause` takes one of these codes:

  | Code | Cause |
  |---|---|
  | 0 | none |
  | 1 | output overvoltage |
  | 2 | switch-node overvoltage |
  | 3 | overcurrent |
  | 4 | overtemperature |
  | 5 | shorted string |
  | 6 | soft-start timeout |

  When several faults arrive together, the priority is 2, then 5, then 1, then 3, then 4, then 6. A latching fault wins over auto-recovery in the same cycle. The code is kept unchanged until the latch is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Device enable; low clears latched faults |
| mode_auto | input | 1 | Fault mode: 0 latch, 1 auto-restart |
| ovp_flag | input | 1 | Output overvoltage flag |
| swov_flag | input | 1 | Switch-node overvoltage flag |
| ocp_flag | input | 1 | Boost overcurrent flag |
| otp_flag | input | 1 | Overtemperature flag |
| temp_ok_flag | input | 1 | Temperature back below recovery level |
| uvlo_flag | input | 1 | Input undervoltage flag |
| ssto_flag | input | 1 | Soft-start timeout flag |
| short_flag | input | NCH | Per-channel shorted-string flags |
| active_mask | input | NCH | Channels in use |
| in_reg | input | NCH | Channels currently in regulation |
| shutdown | output | 1 | Power stage off request |
| restart_ss | output | 1 | Rerun soft start request |
| str_disable | output | NCH | Per-channel string removal mask |
| fault_pd | output | 1 | Pull-down enable of the open-drain fault pin (1 = pin low) |
| first_cause | output | 3 | Cause of the latched shutdown |

## Verification
Two functions can collide in one cycle: a latching event and an auto-mode recovery path. The bench raises, in auto mode, overtemperature together with switch-node overvoltage on the same clock edge. It expects latched shutdown with cause 2, not the thermal wait. It then removes both faults and sets the recovered flag, and checks that the device stays latched. A second collision raises overvoltage, overcurrent and overtemperature together in latch mode, and expects the priority-selected cause 1.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_RUN   = 3'd1,
        ST_LATCH = 3'd2,
        ST_HOT   = 3'd3,
        ST_UV    = 3'd4
    } fsup_state_e;

    typedef enum logic [2:0] {
        CZ_NONE  = 3'd0,
        CZ_OVP   = 3'd1,
        CZ_SWOV  = 3'd2,
        CZ_OCP   = 3'd3,
        CZ_OTP   = 3'd4,
        CZ_SHORT = 3'd5,
        CZ_SSTO  = 3'd6
    } fsup_cause_e;

    typedef struct packed {
        logic ovp;
        logic swov;
        logic ocp;
        logic otp;
        logic tok;
        logic uv;
        logic ssto;
    } fsup_flags_t;

    localparam int FSUP_NFLAGS = 7;

endpackage

// File: rtl/fsup_glitch_filter.sv
module fsup_glitch_filter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] clean
);

    logic [W-1:0] seen_q;

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                seen_q[b] <= 1'b0;
                clean[b]  <= 1'b0;
            end else begin
                seen_q[b] <= raw[b];
                if (raw[b] == seen_q[b]) begin
                    clean[b] <= raw[b];
                end
            end
        end
    end

endmodule

// File: rtl/fsup_string_mask.sv
module fsup_string_mask #(
    parameter int NCH = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           trim,
    input  logic [NCH-1:0] active_mask,
    input  logic [NCH-1:0] in_reg,
    output logic [NCH-1:0] mask
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (clear) begin
            mask <= '0;
        end else if (trim) begin
            mask <= mask | (active_mask & ~in_reg);
        end
    end

endmodule

// File: rtl/fsup_fsm.sv
module fsup_fsm
    import fsup_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        mode_auto,
    input  fsup_flags_t f,
    input  logic        short_hit,
    output logic        shutdown,
    output logic        restart_ss,
    output logic        ovp_trim,
    output logic        fault_pd,
    output logic [2:0]  cause
);

    fsup_state_e st_q, st_n;
    fsup_cause_e cz_q, cz_n, pick;
    logic        latch_evt;

    assign latch_evt = f.swov | short_hit |
                       (!mode_auto & (f.ovp | f.ocp | f.otp | f.ssto));

    always_comb begin
        if (f.swov)                   pick = CZ_SWOV;
        else if (short_hit)           pick = CZ_SHORT;
        else if (!mode_auto && f.ovp) pick = CZ_OVP;
        else if (!mode_auto && f.ocp) pick = CZ_OCP;
        else if (!mode_auto && f.otp) pick = CZ_OTP;
        else if (!mode_auto && f.ssto) pick = CZ_SSTO;
        else                          pick = CZ_NONE;
    end

    always_comb begin
        st_n = st_q;
        cz_n = cz_q;
        if (f.uv) begin
            st_n = ST_UV;
            cz_n = CZ_NONE;
        end else if (!enable) begin
            st_n = ST_OFF;
            cz_n = CZ_NONE;
        end else begin
            unique case (st_q)
                ST_OFF, ST_UV: st_n = ST_RUN;
                ST_RUN: begin
                    if (latch_evt) begin
                        st_n = ST_LATCH;
                        cz_n = pick;
                    end else if (mode_auto && f.otp) begin
                        st_n = ST_HOT;
                    end
                end
                ST_HOT: begin
                    if (latch_evt) begin
                        st_n = ST_LATCH;
                        cz_n = pick;
                    end else if (f.tok && !f.otp) begin
                        st_n = ST_RUN;
                    end
                end
                ST_LATCH: st_n = ST_LATCH;
                default:  st_n = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_OFF;
            cz_q <= CZ_NONE;
        end else begin
            st_q <= st_n;
            cz_q <= cz_n;
        end
    end

    always_comb begin
        shutdown   = (st_q != ST_RUN);
        ovp_trim   = (st_q == ST_RUN) && mode_auto && f.ovp;
        restart_ss = (st_q == ST_RUN) && mode_auto && (f.ocp || f.ssto) && !latch_evt;
        fault_pd   = (st_q == ST_LATCH) || (st_q == ST_HOT) || (st_q == ST_UV) ||
                     restart_ss || ovp_trim;
        cause      = cz_q;
    end

endmodule

// File: rtl/led_fault_supervisor.sv
module led_fault_supervisor
    import fsup_pkg::*;
#(
    parameter int NCH = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic           mode_auto,
    input  logic           ovp_flag,
    input  logic           swov_flag,
    input  logic           ocp_flag,
    input  logic           otp_flag,
    input  logic           temp_ok_flag,
    input  logic           uvlo_flag,
    input  logic           ssto_flag,
    input  logic [NCH-1:0] short_flag,
    input  logic [NCH-1:0] active_mask,
    input  logic [NCH-1:0] in_reg,
    output logic           shutdown,
    output logic           restart_ss,
    output logic [NCH-1:0] str_disable,
    output logic           fault_pd,
    output logic [2:0]     first_cause
);

    localparam int FW = FSUP_NFLAGS + NCH;

    logic [FW-1:0] raw_vec, clean_vec;
    fsup_flags_t   flt;
    logic [NCH-1:0] short_f;
    logic          short_hit;
    logic          ovp_trim;
    logic          uv_f;

    assign raw_vec = {short_flag, ovp_flag, swov_flag, ocp_flag, otp_flag,
                      temp_ok_flag, uvlo_flag, ssto_flag};

    fsup_glitch_filter #(.W(FW)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (raw_vec),
        .clean (clean_vec)
    );

    assign flt       = fsup_flags_t'(clean_vec[FSUP_NFLAGS-1:0]);
    assign short_f   = clean_vec[FW-1:FSUP_NFLAGS];
    assign short_hit = |(short_f & active_mask);
    assign uv_f      = flt.uv;

    fsup_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .mode_auto  (mode_auto),
        .f          (flt),
        .short_hit  (short_hit),
        .shutdown   (shutdown),
        .restart_ss (restart_ss),
        .ovp_trim   (ovp_trim),
        .fault_pd   (fault_pd),
        .cause      (first_cause)
    );

    fsup_string_mask #(.NCH(NCH)) u_mask (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (!enable || uv_f),
        .trim        (ovp_trim),
        .active_mask (active_mask),
        .in_reg      (in_reg),
        .mask        (str_disable)
    );

endmodule

// File: rtl/fsup_checker.sv
module fsup_checker #(
    parameter int NCH = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           enable,
    input logic           mode_auto,
    input logic           uv_f,
    input logic           shutdown,
    input logic           restart_ss,
    input logic           fault_pd,
    input logic [NCH-1:0] str_disable,
    input logic [2:0]     first_cause
);

    assert_off_shutdown_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> shutdown);

    assert_uv_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        uv_f |=> (shutdown && first_cause == 3'd0));

    assert_latch_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (first_cause != 3'd0 && enable && !uv_f) |=> (first_cause == $past(first_cause)));

    assert_cause_shutdown_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (first_cause != 3'd0) |-> shutdown);

    assert_mask_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !uv_f) |=> ((str_disable & $past(str_disable)) == $past(str_disable)));

    assert_restart_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        restart_ss |-> (!shutdown && mode_auto));

    assert_restart_pin_R11: assert property (@(posedge clk) disable iff (!rst_n)
        restart_ss |-> fault_pd);

endmodule

bind led_fault_supervisor fsup_checker #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .mode_auto   (mode_auto),
    .uv_f        (uv_f),
    .shutdown    (shutdown),
    .restart_ss  (restart_ss),
    .fault_pd    (fault_pd),
    .str_disable (str_disable),
    .first_cause (first_cause)
);

// File: tb/led_fault_supervisor_test.sv
module led_fault_supervisor_test;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, mode_auto = 1'b0;
    logic ovp_flag = 1'b0, swov_flag = 1'b0, ocp_flag = 1'b0, otp_flag = 1'b0;
    logic temp_ok_flag = 1'b0, uvlo_flag = 1'b0, ssto_flag = 1'b0;
    logic [NCH-1:0] short_flag = '0;
    logic [NCH-1:0] active_mask = 6'b001111;
    logic [NCH-1:0] in_reg = '1;
    logic shutdown, restart_ss, fault_pd;
    logic [NCH-1:0] str_disable;
    logic [2:0] first_cause;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    led_fault_supervisor #(.NCH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode_auto(mode_auto),
        .ovp_flag(ovp_flag), .swov_flag(swov_flag), .ocp_flag(ocp_flag),
        .otp_flag(otp_flag), .temp_ok_flag(temp_ok_flag), .uvlo_flag(uvlo_flag),
        .ssto_flag(ssto_flag), .short_flag(short_flag), .active_mask(active_mask),
        .in_reg(in_reg), .shutdown(shutdown), .restart_ss(restart_ss),
        .str_disable(str_disable), .fault_pd(fault_pd), .first_cause(first_cause)
    );

    typedef struct {
        logic           sd;
        logic           rs;
        logic           pd;
        logic [2:0]     cz;
        logic [NCH-1:0] mk;
        string          tag;
    } exp_t;

    exp_t sb[$];

    // monitor: pops one expected item per falling edge and compares
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (shutdown !== e.sd || restart_ss !== e.rs || fault_pd !== e.pd ||
                first_cause !== e.cz || str_disable !== e.mk) begin
                errors++;
                $display("FAIL %s actual sd=%b rs=%b pd=%b cz=%0d mk=%b expected sd=%b rs=%b pd=%b cz=%0d mk=%b",
                         e.tag, shutdown, restart_ss, fault_pd, first_cause, str_disable,
                         e.sd, e.rs, e.pd, e.cz, e.mk);
            end
        end
    end

    task automatic run_cycles(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic expect_out(input logic sd, input logic rs, input logic pd,
                              input logic [2:0] cz, input logic [NCH-1:0] mk,
                              input string tag);
        exp_t e;
        e.sd = sd; e.rs = rs; e.pd = pd; e.cz = cz; e.mk = mk; e.tag = tag;
        sb.push_back(e);
        run_cycles(1);
    endtask

    task automatic toggle_enable();
        enable = 1'b0;
        run_cycles(3);
        enable = 1'b1;
        run_cycles(3);
    endtask

    initial begin
        run_cycles(3);
        rst_n = 1'b1;
        run_cycles(2);
        expect_out(1, 0, 0, 0, '0, "R1 disabled after reset");

        enable = 1'b1;
        run_cycles(4);
        expect_out(0, 0, 0, 0, '0, "R1 running");

        // R2: single-cycle glitch on a latching input is ignored
        swov_flag = 1'b1;
        run_cycles(1);
        swov_flag = 1'b0;
        run_cycles(5);
        expect_out(0, 0, 0, 0, '0, "R2 glitch ignored");

        // R2/R3: latency and latched overcurrent in mode low
        mode_auto = 1'b0;
        ocp_flag = 1'b1;
        expect_out(0, 0, 0, 0, '0, "R2 not yet after one edge");
        expect_out(0, 0, 0, 0, '0, "R2 not yet after two edges");
        expect_out(1, 0, 1, 3, '0, "R3 overcurrent latched");
        ocp_flag = 1'b0;
        swov_flag = 1'b1;
        run_cycles(4);
        expect_out(1, 0, 1, 3, '0, "R12 first cause kept");
        swov_flag = 1'b0;
        run_cycles(4);
        expect_out(1, 0, 1, 3, '0, "R8 latch persists");
        enable = 1'b0;
        run_cycles(3);
        expect_out(1, 0, 0, 0, '0, "R8 enable low clears");
        enable = 1'b1;
        run_cycles(3);
        expect_out(0, 0, 0, 0, '0, "R8 resumes after toggle");

        otp_flag = 1'b1;
        run_cycles(4);
        expect_out(1, 0, 1, 4, '0, "R3 overtemperature latched");
        otp_flag = 1'b0;
        toggle_enable();

        ssto_flag = 1'b1;
        run_cycles(4);
        expect_out(1, 0, 1, 6, '0, "R3 soft-start timeout latched");
        ssto_flag = 1'b0;
        toggle_enable();

        ovp_flag = 1'b1;
        run_cycles(4);
        expect_out(1, 0, 1, 1, '0, "R3 overvoltage latched");
        ovp_flag = 1'b0;
        toggle_enable();

        ovp_flag = 1'b1; ocp_flag = 1'b1; otp_flag = 1'b1;
        run_cycles(4);
        expect_out(1, 0, 1, 1, '0, "R12 simultaneous priority");
        ovp_flag = 1'b0; ocp_flag = 1'b0; otp_flag = 1'b0;
        toggle_enable();

        // auto mode
        mode_auto = 1'b1;
        ocp_flag = 1'b1;
        run_cycles(4);
        expect_out(0, 1, 1, 0, '0, "R5 overcurrent restart");
        ocp_flag = 1'b0;
        run_cycles(4);
        expect_out(0, 0, 0, 0, '0, "R11 restart cleared");
        ssto_flag = 1'b1;
        run_cycles(4);
        expect_out(0, 1, 1, 0, '0, "R5 timeout restart");
        ssto_flag = 1'b0;
        run_cycles(4);

        otp_flag = 1'b1;
        run_cycles(4);
        expect_out(1, 0, 1, 0, '0, "R6 thermal wait");
        otp_flag = 1'b0;
        run_cycles(4);
        expect_out(1, 0, 1, 0, '0, "R6 waits for recovered flag");
        temp_ok_flag = 1'b1;
        run_cycles(4);
        expect_out(0, 0, 0, 0, '0, "R6 auto resume");
        temp_ok_flag = 1'b0;
        run_cycles(2);

        short_flag = 6'b100000;
        run_cycles(5);
        expect_out(0, 0, 0, 0, '0, "R10 inactive channel short ignored");
        short_flag = '0;
        run_cycles(3);

        short_flag = 6'b000010;
        run_cycles(4);
        expect_out(1, 0, 1, 5, '0, "R4 active short latches in auto");
        short_flag = '0;
        toggle_enable();

        swov_flag = 1'b1;
        run_cycles(4);
        expect_out(1, 0, 1, 2, '0, "R4 switch overvoltage latches in auto");
        swov_flag = 1'b0;
        uvlo_flag = 1'b1;
        run_cycles(4);
        expect_out(1, 0, 1, 0, '0, "R9 undervoltage clears latch");
        uvlo_flag = 1'b0;
        run_cycles(4);
        expect_out(0, 0, 0, 0, '0, "R9 resume after undervoltage");

        in_reg = 6'b111010;
        ovp_flag = 1'b1;
        run_cycles(4);
        expect_out(0, 0, 1, 0, 6'b000101, "R7 strings removed");
        ovp_flag = 1'b0;
        in_reg = '1;
        run_cycles(4);
        expect_out(0, 0, 0, 0, 6'b000101, "R7 mask held");
        enable = 1'b0;
        run_cycles(3);
        expect_out(1, 0, 0, 0, '0, "R7 mask cleared by enable low");
        enable = 1'b1;
        run_cycles(3);

        otp_flag = 1'b1; swov_flag = 1'b1;
        run_cycles(4);
        expect_out(1, 0, 1, 2, '0, "R12 latch beats thermal recovery");
        otp_flag = 1'b0; swov_flag = 1'b0; temp_ok_flag = 1'b1;
        run_cycles(4);
        expect_out(1, 0, 1, 2, '0, "R12 recovered flag does not release");
        temp_ok_flag = 1'b0;
        toggle_enable();

        run_cycles(2);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule